// File: doc/BRIEF.md
# Packed Attribute Vector Loader

This block accepts 32-bit register writes on a plain address / data / write-enable port. Three data addresses form a group, and any write to that group lands in the next slot of a three-word staging buffer. The third word completes a vector. The 96 bits of the three words then hold four 24-bit components. The block unpacks them in reversed component order and stores the resulting 4-component vector in a 16-entry attribute memory. The memory position comes from a destination index register.

The index register has its own address. It steps forward by one after every stored vector, so a stream of 3·N data writes fills N consecutive entries. A completed vector whose index is 16 or more is dropped, and the block raises an error pulse instead. Writing the index register sets a new starting point and throws away any partial vector.

A synchronous read port returns any stored entry one cycle after its address is presented. The block treats the components as opaque 24-bit patterns.

Top module: `attr_pack_loader`

## Requirements
- R1: Writes with `wr_en` high to address 0x233, 0x234 or 0x235 all feed one staging buffer in arrival order. The particular address used within the group does not matter.
- R2: A write counter selects the staging slot. The third data write completes the vector and returns the counter to zero, so the following three data writes form a fresh vector.
- R3: The three words, concatenated first-to-last, are 96 bits. Take the top 24 bits as w, the next 24 as z, the next 24 as y and the lowest 24 as x. The stored and returned vector is {x, y, z, w}, with x in bits 95:72 and w in bits 23:0.
- R4: A completed vector is written to entry `cur_idx` of the 16-entry memory. `rd_data` presents entry `rd_addr` one clock after `rd_addr` is sampled.
- R5: After a vector is stored, `cur_idx` increases by one on the same clock edge.
- R6: When a vector completes with `cur_idx` at 16 or above, no entry changes and `cur_idx` keeps its value. `err` is high for exactly the one cycle after the completing write.
- R7: A write to address 0x232 loads `cur_idx` from `wr_data[4:0]` and clears the write counter, so any words already staged are discarded.
- R8: A write to any other address leaves the memory, the staging buffer, the counter and `cur_idx` unchanged. Cycles with `wr_en` low also leave them unchanged.
- R9: After reset every memory entry reads as zero, `cur_idx` is 0 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Memory entry to read |
| rd_data | output | 96 | Stored vector {x, y, z, w}, one cycle after rd_addr |
| cur_idx | output | 5 | Destination index register |
| err | output | 1 | One-cycle pulse on a rejected vector |

## Verification
The hardest situation to reach is a partial vector left in the staging buffer and then interrupted: by an index reload, by writes to neighbouring addresses just outside the group, or by idle cycles. Only the words that follow show whether the counter was cleared or left alone. The bench builds each such case directly. It stages one or two words, inserts the interrupting write, completes a vector with new words, and compares the entry it lands in, and the untouched entries, against the packing computed in the bench. Rejection at index 16 and 31 is reached by loading the index register directly after a full 16-entry sweep.

// File: rtl/attr_pack_loader.sv
module attr_pack_loader #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DATA_BASE = 'h233,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 'h232
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0]  rd_addr,
  output logic [3*DATA_W-1:0]       rd_data,
  output logic [$clog2(DEPTH):0]    cur_idx,
  output logic                      err
);
  localparam int RD_W  = $clog2(DEPTH);
  localparam int IDX_W = RD_W + 1;
  localparam int VEC_W = 3 * DATA_W;
  localparam int COMP_W = VEC_W / 4;

  logic [DATA_W-1:0] stage0, stage1;
  logic [1:0]        cnt;
  logic [VEC_W-1:0]  mem [DEPTH];
  logic [VEC_W-1:0]  packed_in, unpacked;

  wire data_hit = wr_en && (wr_addr >= DATA_BASE) && (wr_addr <= DATA_BASE + ADDR_W'(2));
  wire idx_hit  = wr_en && (wr_addr == IDX_ADDR);
  wire complete = data_hit && (cnt == 2'd2);
  wire in_range = cur_idx < IDX_W'(DEPTH);

  assign packed_in = {stage0, stage1, wr_data};

  always_comb begin
    for (int c = 0; c < 4; c++)
      unpacked[c*COMP_W +: COMP_W] = packed_in[(3-c)*COMP_W +: COMP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      stage0  <= '0;
      stage1  <= '0;
      cur_idx <= '0;
      err     <= 1'b0;
    end else begin
      err <= complete && !in_range;
      if (idx_hit) begin
        cur_idx <= wr_data[IDX_W-1:0];
        cnt     <= '0;
      end else if (data_hit) begin
        if (cnt == 2'd0) stage0 <= wr_data;
        if (cnt == 2'd1) stage1 <= wr_data;
        cnt <= complete ? 2'd0 : cnt + 2'd1;
        if (complete && in_range) cur_idx <= cur_idx + IDX_W'(1);
      end
    end
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[e] <= '0;
        else if (complete && in_range && cur_idx[RD_W-1:0] == RD_W'(e)) mem[e] <= unpacked;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/attr_pack_loader_chk.sv
module attr_pack_loader_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DATA_BASE = 'h233,
  parameter logic [ADDR_W-1:0] IDX_ADDR  = 'h232
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic [1:0]               cnt,
  input logic [$clog2(DEPTH):0]   cur_idx,
  input logic                     err
);
  localparam int IDX_W = $clog2(DEPTH) + 1;
  wire grp = wr_en && wr_addr >= DATA_BASE && wr_addr <= DATA_BASE + ADDR_W'(2);
  wire other = !wr_en || (!grp && wr_addr != IDX_ADDR);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt != 2'd3);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && cnt == 2'd2) |=> cnt == 2'd0);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && cnt == 2'd2 && cur_idx < IDX_W'(DEPTH)) |=> cur_idx == $past(cur_idx) + IDX_W'(1) && !err);

  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && cnt == 2'd2 && cur_idx >= IDX_W'(DEPTH)) |=> err && $stable(cur_idx));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp && cnt == 2'd2) |=> !err);

  p_idx_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == IDX_ADDR) |=> cnt == 2'd0 && cur_idx == $past(wr_data[IDX_W-1:0]));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    other |=> $stable(cnt) && $stable(cur_idx));
endmodule

bind attr_pack_loader attr_pack_loader_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_BASE(DATA_BASE), .IDX_ADDR(IDX_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt(cnt), .cur_idx(cur_idx), .err(err)
);

// File: tb/sim_attr_pack_loader.sv
module sim_attr_pack_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [95:0] rd_data;
  logic [4:0]  cur_idx;
  logic        err;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [95:0] model [16];

  always #4 clk = ~clk;

  attr_pack_loader u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cur_idx(cur_idx), .err(err));

  function automatic logic [95:0] expect_vec(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [95:0] cat = {a, b, c};
    return {cat[23:0], cat[47:24], cat[71:48], cat[95:72]};
  endfunction

  function automatic logic [31:0] pat(int n);
    return (32'h9E3779B9 * (n + 1)) ^ (32'h00FF00FF << (n % 8));
  endfunction

  task automatic chk(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      rd_addr = 4'(e);
      @(negedge clk);
      chk(rd_data === model[e], tag, rd_data, model[e]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c;
    for (int e = 0; e < 16; e++) model[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk(cur_idx === 5'd0, "R9 idx", 96'(cur_idx), 96'd0);
    chk(err === 1'b0, "R9 err", 96'(err), 96'd0);
    read_all("R9 entry zero");

    // R1 R2 R3 R4 R5 sweep over all entries with rotating group addresses
    for (int e = 0; e < 16; e++) begin
      a = pat(3*e); b = pat(3*e+1); c = pat(3*e+2);
      wr(10'h233 + 10'((e) % 3), a);
      wr(10'h233 + 10'((e + 1) % 3), b);
      wr(10'h233 + 10'((e + 2) % 3), c);
      model[e] = expect_vec(a, b, c);
      chk(cur_idx === 5'(e + 1), "R5 index step", 96'(cur_idx), 96'(e + 1));
      chk(err === 1'b0, "R5 no err", 96'(err), 96'd0);
    end
    read_all("R1 R3 R4 sweep");

    // R6 rejection at 16 and 31
    for (int k = 0; k < 2; k++) begin
      logic [4:0] bad = (k == 0) ? 5'd16 : 5'd31;
      wr(10'h232, 32'(bad));
      wr(10'h233, 32'hDEAD0001);
      wr(10'h234, 32'hDEAD0002);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 10'h235; wr_data = 32'hDEAD0003;
      @(negedge clk);
      wr_en = 1'b0;
      chk(err === 1'b1, "R6 err raised", 96'(err), 96'd1);
      chk(cur_idx === bad, "R6 idx held", 96'(cur_idx), 96'(bad));
      @(negedge clk);
      chk(err === 1'b0, "R6 err single cycle", 96'(err), 96'd0);
    end
    read_all("R6 memory unchanged");

    // R7 index reload discards a partial vector
    wr(10'h232, 32'd3);
    wr(10'h233, 32'h11111111);
    wr(10'h235, 32'h22222222);
    wr(10'h232, 32'hFFFFFFE5);
    chk(cur_idx === 5'd5, "R7 idx load", 96'(cur_idx), 96'd5);
    a = pat(100); b = pat(101); c = pat(102);
    wr(10'h234, a); wr(10'h234, b); wr(10'h234, c);
    model[5] = expect_vec(a, b, c);
    chk(cur_idx === 5'd6, "R7 idx after", 96'(cur_idx), 96'd6);
    read_all("R7 partial discarded");

    // R8 other addresses and idle cycles ignored mid-vector
    wr(10'h232, 32'd7);
    a = pat(200); b = pat(201); c = pat(202);
    wr(10'h233, a);
    wr(10'h236, 32'hBAD00001);
    wr(10'h231, 32'hBAD00002);
    wr(10'h000, 32'hBAD00003);
    @(negedge clk);
    wr_addr = 10'h233; wr_data = 32'hBAD00004;
    repeat (3) @(negedge clk);
    chk(cur_idx === 5'd7, "R8 idx unchanged", 96'(cur_idx), 96'd7);
    wr(10'h235, b);
    wr(10'h234, c);
    model[7] = expect_vec(a, b, c);
    chk(cur_idx === 5'd8, "R8 idx after", 96'(cur_idx), 96'd8);
    read_all("R8 stray writes ignored");

    // R2 back-to-back vectors without idle
    a = pat(300); b = pat(301); c = pat(302);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 10'h233; wr_data = a;      @(negedge clk);
    wr_addr = 10'h234; wr_data = b;      @(negedge clk);
    wr_addr = 10'h235; wr_data = c;      @(negedge clk);
    wr_addr = 10'h233; wr_data = c;      @(negedge clk);
    wr_addr = 10'h233; wr_data = b;      @(negedge clk);
    wr_addr = 10'h233; wr_data = a;      @(negedge clk);
    wr_en = 1'b0;
    model[8] = expect_vec(a, b, c);
    model[9] = expect_vec(c, b, a);
    chk(cur_idx === 5'd10, "R2 back-to-back idx", 96'(cur_idx), 96'd10);
    read_all("R2 back-to-back");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule